// File: doc/BRIEF.md
# Conditional Branch and Skip Resolver

This block works out where the program counter goes after a conditional control-flow instruction has been decoded. The decoder hands it an operation class, the 8-bit status flags, a flag or bit selector, a wanted polarity, a signed relative offset, the current program counter, the result of an equality compare, the byte whose bit a skip tests, and whether the instruction after the current one is two words long. One clock later the block presents the next program counter, whether the branch was taken or the skip happened, and how many cycles the instruction costs.

Branches go relative to the word after the branch. Skips step over the following instruction, so the skip distance depends on that instruction's length. Requests may arrive on every cycle. Each result is presented for exactly one cycle and then holds while no request is pending.

Top module: `branch_skip_unit`

## Requirements
- R1: While reset is asserted, and after it until the first request, out_valid, taken, cycles and next_pc are all zero.
- R2: Operation class 1 (flag branch) is taken exactly when status[flag_sel] equals want_set.
- R3: A taken branch gives next_pc = pc + sign-extended offset + 1, modulo 2^PC_W. A not-taken branch gives pc + 1.
- R4: Operation class 2 (signed-compare branch) is taken exactly when (status[2] XOR status[3]) equals want_set, where status bit 2 is the negative flag and bit 3 is the overflow flag. The value 0 selects greater-or-equal and 1 selects less-than.
- R5: Operation class 3 (skip on equal) skips exactly when cmp_equal is 1. want_set has no effect on it.
- R6: Operation classes 4 (register-bit skip) and 5 (I/O-bit skip) skip exactly when test_byte[flag_sel] equals want_set.
- R7: A skip gives next_pc = pc + 2 when next_two_word is 0 and pc + 3 when it is 1. A skip that does not happen gives pc + 1. next_two_word has no effect on branches.
- R8: Cycle counts are as follows. Branches and classes 3 and 4 cost 1 cycle, or 2 when taken or skipping. Class 5 costs 2 cycles, or 3 when skipping.
- R9: Operation class 0 and the unused classes 6 and 7 give next_pc = pc + 1, taken 0 and cycles 1, whatever the status flags are.
- R10: out_valid is 1 in exactly the cycle after a cycle with req_valid high. In a cycle after req_valid low, next_pc, taken and cycles keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| op_kind | input | 3 | Operation class (0 sequential, 1 flag branch, 2 signed branch, 3 skip-equal, 4 register-bit skip, 5 I/O-bit skip) |
| status | input | 8 | Status flags (bit 2 negative, bit 3 overflow) |
| flag_sel | input | 3 | Status flag index for branches, bit index for bit skips |
| want_set | input | 1 | Polarity the condition must match |
| offset | input | K_W | Signed branch displacement |
| pc | input | PC_W | Address of the current instruction |
| cmp_equal | input | 1 | Equality compare result for skip-equal |
| test_byte | input | 8 | Register or I/O byte tested by bit skips |
| next_two_word | input | 1 | The following instruction is two words long |
| out_valid | output | 1 | Result presented this cycle |
| next_pc | output | PC_W | Resolved next program counter |
| taken | output | 1 | Branch taken or skip performed |
| cycles | output | 2 | Cycle cost of the instruction |

## Verification
Two things can happen in the same cycle: the block presents one result, and the register stage captures the next request. Both are provoked by long runs of requests on every cycle, with random operation classes and occasional idle cycles mixed in, so each new request and the previous result overlap. Every presented result is compared with a bench model of the request accepted one cycle earlier, and each idle cycle is checked for an unchanged result. Directed cases add wrap-around at both ends of the address space, the extreme offsets, and the unused classes.

// File: rtl/branch_skip_unit.sv
module branch_skip_unit #(
  parameter int PC_W = 16,
  parameter int K_W  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      op_kind,
  input  logic [7:0]      status,
  input  logic [2:0]      flag_sel,
  input  logic            want_set,
  input  logic [K_W-1:0]  offset,
  input  logic [PC_W-1:0] pc,
  input  logic            cmp_equal,
  input  logic [7:0]      test_byte,
  input  logic            next_two_word,
  output logic            out_valid,
  output logic [PC_W-1:0] next_pc,
  output logic            taken,
  output logic [1:0]      cycles
);

  localparam logic [2:0] OP_SEQ   = 3'd0;
  localparam logic [2:0] OP_BFLAG = 3'd1;
  localparam logic [2:0] OP_BSIGN = 3'd2;
  localparam logic [2:0] OP_SKEQ  = 3'd3;
  localparam logic [2:0] OP_SKREG = 3'd4;
  localparam logic [2:0] OP_SKIO  = 3'd5;
  localparam int         EXT_W    = PC_W - K_W;
  localparam int         NEG_BIT  = 2;
  localparam int         OVF_BIT  = 3;

  logic            hit, is_branch, is_skip;
  logic [1:0]      base_cost;
  logic [PC_W-1:0] disp, br_target, sk_target, seq_pc, pc_d;

  assign disp      = {{EXT_W{offset[K_W-1]}}, offset};
  assign seq_pc    = pc + PC_W'(1);
  assign br_target = seq_pc + disp;
  assign sk_target = pc + (next_two_word ? PC_W'(3) : PC_W'(2));

  always_comb begin
    hit       = 1'b0;
    is_branch = 1'b0;
    is_skip   = 1'b0;
    base_cost = 2'd1;
    case (op_kind)
      OP_BFLAG: begin
        is_branch = 1'b1;
        hit       = (status[flag_sel] == want_set);
      end
      OP_BSIGN: begin
        is_branch = 1'b1;
        hit       = ((status[NEG_BIT] ^ status[OVF_BIT]) == want_set);
      end
      OP_SKEQ: begin
        is_skip = 1'b1;
        hit     = cmp_equal;
      end
      OP_SKREG: begin
        is_skip = 1'b1;
        hit     = (test_byte[flag_sel] == want_set);
      end
      OP_SKIO: begin
        is_skip   = 1'b1;
        hit       = (test_byte[flag_sel] == want_set);
        base_cost = 2'd2;
      end
      default: ;
    endcase
  end

  assign pc_d = !hit     ? seq_pc :
                is_branch ? br_target :
                is_skip   ? sk_target : seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      cycles    <= 2'd0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        next_pc <= pc_d;
        taken   <= hit;
        cycles  <= base_cost + {1'b0, hit};
      end
    end
  end

  a_r10_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(req_valid)));

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(next_pc) && $stable(taken) && $stable(cycles)));

  a_r7_no_taken_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !taken) |-> (next_pc == $past(pc) + PC_W'(1)));

  a_r5_skip_eq_follows_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_kind) == OP_SKEQ) |-> (taken == $past(cmp_equal)));

  a_r8_cost_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cycles != 2'd0 && (cycles != 2'd3 || $past(op_kind) == OP_SKIO)));

  a_r9_sequential_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(op_kind) == OP_SEQ || $past(op_kind) > OP_SKIO)) |-> (!taken && cycles == 2'd1));

endmodule

// File: tb/branch_skip_unit_bench.sv
module branch_skip_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16;
  localparam int K_W  = 7;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic [2:0]      op_kind;
  logic [7:0]      status;
  logic [2:0]      flag_sel;
  logic            want_set;
  logic [K_W-1:0]  offset;
  logic [PC_W-1:0] pc;
  logic            cmp_equal;
  logic [7:0]      test_byte;
  logic            next_two_word;
  logic            out_valid;
  logic [PC_W-1:0] next_pc;
  logic            taken;
  logic [1:0]      cycles;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_skip_unit #(.PC_W(PC_W), .K_W(K_W)) u_branch_skip_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_kind(op_kind),
    .status(status), .flag_sel(flag_sel), .want_set(want_set), .offset(offset),
    .pc(pc), .cmp_equal(cmp_equal), .test_byte(test_byte),
    .next_two_word(next_two_word), .out_valid(out_valid), .next_pc(next_pc),
    .taken(taken), .cycles(cycles)
  );

  function automatic logic [PC_W+2:0] model(input logic [2:0] k, input logic [7:0] st,
      input logic [2:0] sel, input logic pol, input logic [K_W-1:0] off,
      input logic [PC_W-1:0] p, input logic eq, input logic [7:0] tb, input logic two);
    logic c;
    logic [PC_W-1:0] np;
    logic [1:0] cy;
    logic [PC_W-1:0] sx;
    sx = PC_W'($signed(off));
    c = 1'b0; np = p + 1; cy = 2'd1;
    case (k)
      3'd1: begin c = (st[sel] == pol);        if (c) begin np = p + sx + 1; cy = 2; end end
      3'd2: begin c = ((st[2] != st[3]) == pol); if (c) begin np = p + sx + 1; cy = 2; end end
      3'd3: begin c = eq;                       if (c) begin np = p + (two ? 3 : 2); cy = 2; end end
      3'd4: begin c = (tb[sel] == pol);         if (c) begin np = p + (two ? 3 : 2); cy = 2; end end
      3'd5: begin c = (tb[sel] == pol); cy = c ? 2'd3 : 2'd2; if (c) np = p + (two ? 3 : 2); end
      default: ;
    endcase
    return {np, c, cy};
  endfunction

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd1: return "R2/R3/R8";
      3'd2: return "R4/R3/R8";
      3'd3: return "R5/R7/R8";
      3'd4: return "R6/R7/R8";
      3'd5: return "R6/R7/R8 io";
      default: return "R9";
    endcase
  endfunction

  task automatic send(input logic [2:0] k, input logic [7:0] st, input logic [2:0] sel,
      input logic pol, input logic [K_W-1:0] off, input logic [PC_W-1:0] p,
      input logic eq, input logic [7:0] tb, input logic two);
    logic [PC_W+2:0] exp;
    req_valid = 1'b1; op_kind = k; status = st; flag_sel = sel; want_set = pol;
    offset = off; pc = p; cmp_equal = eq; test_byte = tb; next_two_word = two;
    exp = model(k, st, sel, pol, off, p, eq, tb, two);
    @(negedge clk);
    n_checks++;
    if ({out_valid, next_pc, taken, cycles} !== {1'b1, exp}) begin
      n_fail++;
      $display("FAIL %s kind=%0d: got valid=%b pc=%h taken=%b cyc=%0d expected valid=1 pc=%h taken=%b cyc=%0d",
        tag_of(k), k, out_valid, next_pc, taken, cycles, exp[PC_W+2:3], exp[2], exp[1:0]);
    end
  endtask

  task automatic idle();
    logic [PC_W+2:0] prev;
    prev = {next_pc, taken, cycles};
    req_valid = 1'b0; op_kind = 3'($urandom); status = 8'($urandom); pc = 16'($urandom);
    cmp_equal = 1'($urandom); test_byte = 8'($urandom);
    @(negedge clk);
    n_checks++;
    if ({out_valid, next_pc, taken, cycles} !== {1'b0, prev}) begin
      n_fail++;
      $display("FAIL R10 idle: got valid=%b pc=%h taken=%b cyc=%0d expected valid=0 pc=%h taken=%b cyc=%0d",
        out_valid, next_pc, taken, cycles, prev[PC_W+2:3], prev[2], prev[1:0]);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; op_kind = 0; status = 0; flag_sel = 0; want_set = 0;
    offset = 0; pc = 0; cmp_equal = 0; test_byte = 0; next_two_word = 0;
    repeat (3) @(negedge clk);
    n_checks++;
    if ({out_valid, next_pc, taken, cycles} !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: got valid=%b pc=%h taken=%b cyc=%0d expected all zero",
        out_valid, next_pc, taken, cycles);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if ({out_valid, next_pc, taken, cycles} !== '0) begin
      n_fail++;
      $display("FAIL R1 after reset: got valid=%b pc=%h expected all zero", out_valid, next_pc);
    end

    // R3 wrap at top: pc=FFFF, k=0 taken -> 0000
    send(3'd1, 8'h01, 3'd0, 1'b1, 7'd0, 16'hFFFF, 0, 0, 0);
    // R3 most negative offset
    send(3'd1, 8'h80, 3'd7, 1'b1, 7'h40, 16'h0010, 0, 0, 0);
    // R3 most positive offset, wrap
    send(3'd1, 8'h00, 3'd1, 1'b0, 7'h3F, 16'hFFF0, 0, 0, 0);
    // R4 ge (N=V=1) and lt (N=1,V=0)
    send(3'd2, 8'h0C, 3'd5, 1'b0, 7'h05, 16'h1000, 0, 0, 1);
    send(3'd2, 8'h04, 3'd5, 1'b1, 7'h7E, 16'h1000, 0, 0, 1);
    send(3'd2, 8'h04, 3'd5, 1'b0, 7'h7E, 16'h1000, 0, 0, 1);
    // R5 polarity ignored
    send(3'd3, 8'h00, 3'd0, 1'b0, 7'h00, 16'h2000, 1, 0, 1);
    send(3'd3, 8'hFF, 3'd0, 1'b1, 7'h00, 16'h2000, 0, 0, 0);
    // R7 skip wrap at top, two-word
    send(3'd4, 8'h00, 3'd6, 1'b1, 7'h00, 16'hFFFE, 0, 8'h40, 1);
    // R8 io skip both outcomes
    send(3'd5, 8'h00, 3'd3, 1'b0, 7'h00, 16'h0300, 0, 8'hF7, 0);
    send(3'd5, 8'h00, 3'd3, 1'b1, 7'h00, 16'h0300, 0, 8'hF7, 0);
    // R9 unused classes with all flags set
    send(3'd7, 8'hFF, 3'd0, 1'b1, 7'h10, 16'h4444, 1, 8'hFF, 1);
    send(3'd6, 8'hFF, 3'd0, 1'b1, 7'h10, 16'hFFFF, 1, 8'hFF, 1);
    idle();

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) idle();
      else send(3'($urandom_range(0, 7)), 8'($urandom), 3'($urandom), 1'($urandom),
                7'($urandom), 16'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
    end
    idle();
    finish_run();
  end
endmodule